// File: doc/BRIEF.md
# Floating-point multiple transfer sequencer

This block turns one floating-point load/store-multiple instruction word into a stream of micro-ops. It takes the instruction in a valid/ready handshake and holds it in a register. It then emits three transfer micro-ops for each register moved. If the instruction asks for writeback, it adds one final micro-op that adds to or subtracts from the base register. A downstream issue stage consumes the stream through its own valid/ready pair and uses the last flag to retire the whole instruction.

The controller has three states. ST_IDLE waits for an instruction and is the only state in which one is accepted. ST_XFER emits the transfer micro-ops. ST_WBACK emits the writeback micro-op. The transitions are:

- **accept**: from ST_IDLE to ST_XFER on an input handshake.
- **xfer_done_wb**: from ST_XFER to ST_WBACK when the last transfer micro-op is consumed and the writeback bit is set.
- **xfer_done**: from ST_XFER to ST_IDLE when the last transfer micro-op is consumed and the writeback bit is clear.
- **wb_done**: from ST_WBACK to ST_IDLE when the writeback micro-op is consumed.

Top module: `fmx_seq`

## Requirements
- R1: The number of register groups is the two-bit code {instr[22], instr[15]}, with instr[22] as the high bit. Code 00 means 4 groups; codes 01, 10 and 11 mean 1, 2 and 3 groups.
- R2: The stream for one instruction has exactly 3×groups micro-ops, plus one more when the writeback bit instr[21] is 1.
- R3: The displacement is instr[7:0] shifted left by two. Every transfer micro-op carries uop_offset equal to the displacement when the pre-index bit instr[24] is 1, and zero when it is 0.
- R4: Transfer micro-ops come in order. Micro-op n carries group n/3 and slot n mod 3, so group i fills positions 3i to 3i+2.
- R5: The writeback micro-op has uop_is_wb=1. Its uop_wb_word is {instr[31:28], 28'h0} OR 32'h0240_0000 OR (Rn<<16) OR (Rn<<12) OR displacement, where Rn is instr[19:16]. uop_up=1 on it marks an add and uop_up=0 marks a subtract, copied from instr[23].
- R6: uop_last is 1 on the final micro-op of the stream and 0 on every other micro-op.
- R7: Every transfer micro-op copies the load flag from instr[20] to uop_load and the direction from instr[23] to uop_up.
- R8: After reset the block is in ST_IDLE with uop_valid=0 and in_ready=1. in_ready is 1 only in ST_IDLE, so input presented while a stream is in progress is ignored and does not change that stream.
- R9: While uop_valid=1 and uop_ready=0, the presented micro-op stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented |
| in_ready | output | 1 | Block idle and able to accept |
| in_instr | input | 32 | Instruction word |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_group | output | 2 | Register group index |
| uop_slot | output | 2 | Micro-op index within the group (0..2) |
| uop_load | output | 1 | 1 = load, 0 = store |
| uop_up | output | 1 | Direction / add (1) or subtract (0) |
| uop_offset | output | 10 | Start offset of the transfer |
| uop_is_wb | output | 1 | Micro-op is the base writeback |
| uop_wb_word | output | 32 | Encoded writeback operation |
| uop_last | output | 1 | Final micro-op of the instruction |

## Verification
The first micro-op is presented one cycle after the input handshake, because the accept edge loads the instruction register and moves the FSM to ST_XFER. Each later micro-op follows the cycle after the consumer's handshake, and in_ready returns one cycle after the handshake on the last micro-op. The bench changes its inputs at falling edges and checks the outputs at the same falling edge, half a cycle before the edge that acts on them. It moves its expected micro-op number forward only when it has driven uop_ready together with an observed uop_valid. This holds the expected values to the design's timing under an irregular ready pattern, and a stall cycle is checked against the same micro-op as the cycle before it.

// File: rtl/fmx_pkg.sv
package fmx_pkg;
    parameter int CODE_W     = 2;
    parameter int GROUP_UOPS = 3;
    parameter int IMM_W      = 8;
    parameter int DISP_SHIFT = 2;

    localparam int CNT_W  = CODE_W + 1;
    localparam int GRP_W  = CODE_W;
    localparam int SLOT_W = $clog2(GROUP_UOPS);
    localparam int DISP_W = IMM_W + DISP_SHIFT;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_WBACK = 2'd2
    } fmx_state_t;

    typedef struct packed {
        logic [CNT_W-1:0]  groups;
        logic              pre;
        logic              up;
        logic              wb;
        logic              load;
        logic [DISP_W-1:0] disp;
        logic [31:0]       wb_word;
    } fmx_fields_t;
endpackage

// File: rtl/fmx_decode.sv
module fmx_decode
    import fmx_pkg::*;
(
    input  logic [31:0] instr,
    output fmx_fields_t fields
);
    localparam logic [31:0] WB_BASE = 32'h0240_0000;

    logic [CODE_W-1:0] code;
    logic [3:0]        rn;

    always_comb begin
        code = {instr[22], instr[15]};
        rn   = instr[19:16];
        fields.groups  = (code == '0) ? CNT_W'(1 << CODE_W) : {1'b0, code};
        fields.pre     = instr[24];
        fields.up      = instr[23];
        fields.wb      = instr[21];
        fields.load    = instr[20];
        fields.disp    = {instr[IMM_W-1:0], {DISP_SHIFT{1'b0}}};
        fields.wb_word = {instr[31:28], 28'h0} | WB_BASE
                       | {12'h0, rn, 16'h0} | {16'h0, rn, 12'h0}
                       | {{(32-DISP_W){1'b0}}, fields.disp};
    end
endmodule

// File: rtl/fmx_slot_ctr.sv
module fmx_slot_ctr
    import fmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [GRP_W-1:0]  grp,
    output logic [SLOT_W-1:0] slot,
    output logic              group_end
);
    localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(GROUP_UOPS - 1);

    assign group_end = (slot == SLOT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            grp  <= '0;
            slot <= '0;
        end else if (step) begin
            if (group_end) begin
                slot <= '0;
                grp  <= grp + 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    // R4: slot index never leaves the group
    p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= SLOT_MAX);
endmodule

// File: rtl/fmx_seq.sv
module fmx_seq
    import fmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_instr,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [GRP_W-1:0]  uop_group,
    output logic [SLOT_W-1:0] uop_slot,
    output logic              uop_load,
    output logic              uop_up,
    output logic [DISP_W-1:0] uop_offset,
    output logic              uop_is_wb,
    output logic [31:0]       uop_wb_word,
    output logic              uop_last
);
    fmx_state_t  state_q, state_d;
    logic [31:0] instr_q;
    fmx_fields_t f;
    logic        accept, fire, xfer_step, last_group, group_end;

    fmx_decode u_dec (.instr(instr_q), .fields(f));

    fmx_slot_ctr u_ctr (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(xfer_step),
        .grp(uop_group), .slot(uop_slot), .group_end(group_end)
    );

    assign accept     = in_valid && in_ready;
    assign fire       = uop_valid && uop_ready;
    assign xfer_step  = fire && (state_q == ST_XFER);
    assign last_group = ({1'b0, uop_group} == (f.groups - 1'b1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            instr_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) instr_q <= in_instr;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = ST_XFER;
            ST_XFER:  if (xfer_step && group_end && last_group)
                          state_d = f.wb ? ST_WBACK : ST_IDLE;
            ST_WBACK: if (fire) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready    = 1'b0;
        uop_valid   = 1'b0;
        uop_is_wb   = 1'b0;
        uop_last    = 1'b0;
        uop_load    = f.load;
        uop_up      = f.up;
        uop_offset  = f.pre ? f.disp : '0;
        uop_wb_word = f.wb_word;
        unique case (state_q)
            ST_IDLE:  in_ready = 1'b1;
            ST_XFER: begin
                uop_valid = 1'b1;
                uop_last  = group_end && last_group && !f.wb;
            end
            ST_WBACK: begin
                uop_valid = 1'b1;
                uop_is_wb = 1'b1;
                uop_last  = 1'b1;
            end
            default: in_ready = 1'b0;
        endcase
    end

    // R8: no input taken while a stream is being emitted
    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> !in_ready);
    // R9: a stalled micro-op is held
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_group)
            && $stable(uop_slot) && $stable(uop_is_wb) && $stable(uop_offset)));
    // R6: the stream ends right after its last micro-op
    p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && uop_last) |=> (!uop_valid && in_ready));
    // R5: the writeback micro-op is always the final one
    p_wb_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uop_is_wb |-> uop_last);
    // R2: writeback appears only after the final transfer group
    p_wb_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uop_is_wb) |-> ($past(uop_slot) == SLOT_W'(GROUP_UOPS - 1)));
endmodule

// File: tb/fmx_seq_bench.sv
module fmx_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic        uop_valid;
    logic        uop_ready = 1'b0;
    logic [1:0]  uop_group;
    logic [1:0]  uop_slot;
    logic        uop_load, uop_up, uop_is_wb, uop_last;
    logic [9:0]  uop_offset;
    logic [31:0] uop_wb_word;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fmx_seq u_fmx_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_group(uop_group), .uop_slot(uop_slot), .uop_load(uop_load),
        .uop_up(uop_up), .uop_offset(uop_offset), .uop_is_wb(uop_is_wb),
        .uop_wb_word(uop_wb_word), .uop_last(uop_last)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_instr(input logic [31:0] ins);
        int code = {ins[22], ins[15]};
        int groups = (code == 0) ? 4 : code;
        int total = 3 * groups + int'(ins[21]);
        logic [9:0] disp = {ins[7:0], 2'b00};
        logic [31:0] wbw = {ins[31:28], 28'h0} | 32'h0240_0000
                         | ({28'h0, ins[19:16]} << 16) | ({28'h0, ins[19:16]} << 12)
                         | {22'h0, disp};
        int n = 0;
        @(negedge clk);
        chk("R8 idle ready", {31'h0, in_ready}, 32'h1);
        in_valid = 1'b1;
        in_instr = ins;
        @(negedge clk);
        in_instr = ~ins;
        while (n < total) begin
            uop_ready = ((cyc % 3) != 1);
            chk("R8 busy ready low", {31'h0, in_ready}, 32'h0);
            chk("R2 valid", {31'h0, uop_valid}, 32'h1);
            chk("R6 last", {31'h0, uop_last}, {31'h0, (n == total - 1)});
            if (n < 3 * groups) begin
                chk("R4 group", {30'h0, uop_group}, n / 3);
                chk("R4 slot", {30'h0, uop_slot}, n % 3);
                chk("R7 load", {31'h0, uop_load}, {31'h0, ins[20]});
                chk("R7 up", {31'h0, uop_up}, {31'h0, ins[23]});
                chk("R3 offset", {22'h0, uop_offset}, ins[24] ? {22'h0, disp} : 32'h0);
                chk("R1 not wb", {31'h0, uop_is_wb}, 32'h0);
            end else begin
                chk("R5 is_wb", {31'h0, uop_is_wb}, 32'h1);
                chk("R5 word", uop_wb_word, wbw);
                chk("R5 add/sub", {31'h0, uop_up}, {31'h0, ins[23]});
            end
            if (uop_ready && uop_valid) begin
                n++;
                if (n == total) in_valid = 1'b0;
            end
            if (uop_valid !== 1'b1) n = total;
            @(negedge clk);
        end
        uop_ready = 1'b0;
        chk("R2 stream ended", {31'h0, uop_valid}, 32'h0);
        chk("R8 ready again", {31'h0, in_ready}, 32'h1);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset valid", {31'h0, uop_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset ready", {31'h0, in_ready}, 32'h1);
        for (int k = 0; k < 64; k++) begin
            logic [7:0] imm = (k == 0) ? 8'h00 : (k == 63) ? 8'hFF : 8'((k * 37 + 5) & 255);
            logic [31:0] ins = ({28'h0, 4'(k * 5)} << 28) | ({31'h0, k[0]} << 24)
                             | ({31'h0, k[1]} << 23) | ({31'h0, k[5]} << 22)
                             | ({31'h0, k[2]} << 21) | ({31'h0, k[3]} << 20)
                             | ({28'h0, 4'(15 - k)} << 16) | ({31'h0, k[4]} << 15)
                             | 32'h0000_5A00 | {24'h0, imm};
            run_instr(ins);
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule